// File: doc/BRIEF.md
# I2S Fractional Bit-Clock Divider

This block produces the serial bit clock of an I2S master from the system clock, with no PLL and no second clock domain. The division ratio is a true fraction, a 15-bit numerator over a 9-bit denominator, followed by a fixed divide-by-two. The output bit-clock frequency is therefore Fclk / (2 · NUM/DENOM). Each system clock cycle adds the denominator to an accumulator. Whenever the sum reaches the numerator, the numerator is subtracted and the bit clock changes level. Over time this gives exactly DENOM level changes for every NUM system cycles.

Besides the bit-clock level, the block gives the serializer two single-cycle strobes, aligned to the system clock. One marks each rising edge of the bit clock and the other marks each falling edge. The numerator and denominator are captured only while the block is disabled. A request to enable with a ratio below 3.35, or with a zero denominator, is refused. The refusal raises a sticky error flag.

Top module: `i2s_bitclk_fracdiv`

## Requirements
- R1: After reset, `sck_o`, `sck_rise_o`, `sck_fall_o` and `ratio_err_o` are all 0.
- R2: Let E0 be the clock edge that starts the divider. At each later edge k (k ≥ 1), the total number of `sck_o` level changes since E0 equals floor(k·DENOM/NUM). So `sck_o` after edge k equals bit 0 of that count.
- R3: `sck_rise_o` is high for exactly the cycles in which `sck_o` has just gone from 0 to 1. `sck_fall_o` is high for exactly the cycles in which it has just gone from 1 to 0. The two are never high together.
- R4: A start clears the accumulator. `sck_o` is 0 in the cycle after E0, and no strobe is issued in that cycle.
- R5: After any edge that samples `en_i` = 0, `sck_o` is 0 and neither strobe is high. Dropping `en_i` while `sck_o` is 1 produces no falling-edge strobe.
- R6: `num_i` and `den_i` are captured only while the divider is idle. Changes to them while it runs have no effect on the output.
- R7: The divider starts only if DENOM ≠ 0 and NUM·20 ≥ DENOM·67 (ratio ≥ 3.35). Otherwise `ratio_err_o` rises in the cycle after the request, and the divider stays idle with `sck_o` 0 and no strobes.
- R8: `ratio_err_o` stays set until reset. It stays set even while a later valid configuration runs.
- R9: With NUM = 125 and DENOM = 16 (ratio 7.8125), exactly 16 level changes occur in 125 cycles. The 16th is a falling edge at k = 125.
- R10: The boundary ratio NUM = 67, DENOM = 20 is accepted. NUM = 66, DENOM = 20 is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run request; the divider runs while high and a valid ratio was accepted |
| num_i | input | 15 | Ratio numerator, captured while idle |
| den_i | input | 9 | Ratio denominator, captured while idle |
| sck_o | output | 1 | Bit-clock level |
| sck_rise_o | output | 1 | One-cycle strobe with each 0→1 change of `sck_o` |
| sck_fall_o | output | 1 | One-cycle strobe with each 1→0 change of `sck_o` |
| ratio_err_o | output | 1 | Sticky flag: a start was refused for a ratio below 3.35 or a zero denominator |

## Verification
The bench compares the bit-clock level in every cycle against the closed form floor(k·DENOM/NUM). A design with an off-by-one in the accumulator compare, such as `>` instead of `>=`, would drift by one cycle at the first exact hit. It would therefore fail the exact 125/16 case at k = 125. The configuration inputs are scrambled on every cycle of every random run. A divider that read them live instead of from the captured copy would produce wrong edge timing. The bench also probes the ratio threshold at exactly 3.35 and one step below it, and tries a zero denominator. An inverted or shifted compare would either refuse the legal boundary or run the illegal one. Finally, the bench drops the enable while the clock is high. A design that leaked a falling strobe there, or kept toggling, would be caught.

// File: rtl/i2s_fdiv_pkg.sv
`timescale 1ns/1ps
package i2s_fdiv_pkg;
   typedef enum logic [0:0] {
      FD_IDLE = 1'b0,
      FD_RUN  = 1'b1
   } fd_state_e;
endpackage

// File: rtl/i2s_fdiv_ratio_chk.sv
`timescale 1ns/1ps
// Combinational ratio check: ok when den != 0 and num/den >= LIM_N/LIM_D.
module i2s_fdiv_ratio_chk #(
   parameter int NUM_W = 15,
   parameter int DEN_W = 9,
   parameter int LIM_N = 67,
   parameter int LIM_D = 20
) (
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             ok_o
);
   localparam int PROD_W = NUM_W + DEN_W + 8;

   logic [PROD_W-1:0] lhs;
   logic [PROD_W-1:0] rhs;

   if (LIM_N < 1 || LIM_D < 1) begin : g_bad_lim
      $error("ratio limit terms must be positive");
   end
   if (LIM_N > 255 || LIM_D > 255) begin : g_bad_lim_w
      $error("ratio limit terms must fit in 8 bits");
   end

   always_comb begin
      lhs  = PROD_W'(num_i) * PROD_W'(LIM_D);
      rhs  = PROD_W'(den_i) * PROD_W'(LIM_N);
      ok_o = (den_i != '0) && (lhs >= rhs);
   end
endmodule

// File: rtl/i2s_fdiv_accum.sv
`timescale 1ns/1ps
// Fractional phase accumulator: adds den each active cycle, wraps at num.
module i2s_fdiv_accum #(
   parameter int NUM_W = 15,
   parameter int DEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             tick_o
);
   localparam int ACC_W = NUM_W + 1;

   if (DEN_W > NUM_W) begin : g_bad_w
      $error("denominator must not be wider than numerator");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;
   logic [ACC_W-1:0] acc_d;

   always_comb begin
      sum    = acc_q + ACC_W'(den_i);
      tick_o = act_i && (sum >= ACC_W'(num_i));
      if (!act_i)      acc_d = '0;
      else if (tick_o) acc_d = sum - ACC_W'(num_i);
      else             acc_d = sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   // R2
   acc_below_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |-> (acc_q < ACC_W'(num_i)));

   // R4
   acc_clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_i |=> (acc_q == '0));
endmodule

// File: rtl/i2s_fdiv_edge_gen.sv
`timescale 1ns/1ps
// Bit-clock level register and edge strobes.
module i2s_fdiv_edge_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic act_i,
   input  logic tick_i,
   output logic sck_o,
   output logic rise_o,
   output logic fall_o
);
   logic sck_q, rise_q, fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else if (!act_i) begin
         sck_q  <= 1'b0;
         rise_q <= 1'b0;
         fall_q <= 1'b0;
      end else begin
         sck_q  <= sck_q ^ tick_i;
         rise_q <= tick_i & ~sck_q;
         fall_q <= tick_i &  sck_q;
      end
   end

   assign sck_o  = sck_q;
   assign rise_o = rise_q;
   assign fall_o = fall_q;

   // R3
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_q && fall_q));

   // R3
   rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q |-> (sck_q && !$past(sck_q)));

   // R3
   fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_q |-> (!sck_q && $past(sck_q) && $past(act_i)));
endmodule

// File: rtl/i2s_bitclk_fracdiv.sv
`timescale 1ns/1ps
module i2s_bitclk_fracdiv #(
   parameter int NUM_W      = 15,
   parameter int DEN_W      = 9,
   parameter int LIM_N      = 67,
   parameter int LIM_D      = 20,
   parameter bit ERR_STICKY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             sck_o,
   output logic             sck_rise_o,
   output logic             sck_fall_o,
   output logic             ratio_err_o
);
   import i2s_fdiv_pkg::*;

   if (NUM_W < 2 || NUM_W > 31) begin : g_bad_num
      $error("NUM_W out of range");
   end
   if (DEN_W < 1) begin : g_bad_den
      $error("DEN_W out of range");
   end

   fd_state_e        state_q;
   logic [NUM_W-1:0] num_q;
   logic [DEN_W-1:0] den_q;
   logic             err_q;
   logic             cfg_ok;
   logic             start;
   logic             refuse;
   logic             act;
   logic             tick;

   i2s_fdiv_ratio_chk #(
      .NUM_W(NUM_W), .DEN_W(DEN_W), .LIM_N(LIM_N), .LIM_D(LIM_D)
   ) u_ratio (
      .num_i (num_i),
      .den_i (den_i),
      .ok_o  (cfg_ok)
   );

   always_comb begin
      start  = (state_q == FD_IDLE) && en_i && cfg_ok;
      refuse = (state_q == FD_IDLE) && en_i && !cfg_ok;
      act    = (state_q == FD_RUN) && en_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FD_IDLE;
         num_q   <= '0;
         den_q   <= '0;
      end else begin
         if (state_q == FD_IDLE) begin
            num_q <= num_i;
            den_q <= den_i;
         end
         if (start)      state_q <= FD_RUN;
         else if (!en_i) state_q <= FD_IDLE;
      end
   end

   if (ERR_STICKY) begin : g_err_sticky
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      err_q <= 1'b0;
         else if (refuse) err_q <= 1'b1;
      end
   end else begin : g_err_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      err_q <= 1'b0;
         else if (refuse) err_q <= 1'b1;
         else if (start)  err_q <= 1'b0;
      end
   end

   i2s_fdiv_accum #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act),
      .num_i  (num_q),
      .den_i  (den_q),
      .tick_o (tick)
   );

   i2s_fdiv_edge_gen u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act),
      .tick_i (tick),
      .sck_o  (sck_o),
      .rise_o (sck_rise_o),
      .fall_o (sck_fall_o)
   );

   assign ratio_err_o = err_q;

   // R5
   disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!sck_o && !sck_rise_o && !sck_fall_o));

   // R6
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == FD_RUN) |=> ($stable(num_q) && $stable(den_q)));

   // R7
   refuse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      refuse |=> (state_q == FD_IDLE && ratio_err_o));

   // R8
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ERR_STICKY && ratio_err_o) |=> ratio_err_o);

   // R4
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!sck_o && !sck_rise_o && !sck_fall_o));
endmodule

// File: tb/tb_i2s_bitclk_fracdiv.sv
`timescale 1ns/1ps
module tb_i2s_bitclk_fracdiv;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0;
   logic [14:0] num_i = '0;
   logic [8:0]  den_i = '0;
   logic        sck_o, sck_rise_o, sck_fall_o, ratio_err_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   i2s_bitclk_fracdiv dut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .num_i(num_i), .den_i(den_i),
      .sck_o(sck_o), .sck_rise_o(sck_rise_o), .sck_fall_o(sck_fall_o),
      .ratio_err_o(ratio_err_o)
   );

   function automatic longint edges_at(longint k, longint num, longint den);
      return (k * den) / num;
   endfunction

   function automatic bit ratio_ok(int num, int den);
      return (den != 0) && (num * 20 >= den * 67);
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      en_i  = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Called at a negedge with en_i low; leaves the divider running.
   task automatic run_check(int num, int den, int cycles, bit scramble, string tag);
      longint t, tp;
      num_i = 15'(num);
      den_i = 9'(den);
      en_i  = 1'b1;
      @(negedge clk);
      chk({tag, " R4 sck after start"}, sck_o, 0);
      chk({tag, " R4 no strobe after start"}, sck_rise_o | sck_fall_o, 0);
      tp = 0;
      for (int k = 1; k <= cycles; k++) begin
         if (scramble) begin
            num_i = 15'($urandom);
            den_i = 9'($urandom);
         end
         @(negedge clk);
         t = edges_at(k, num, den);
         chk({tag, " R2 R6 sck level"}, sck_o, t % 2);
         chk({tag, " R3 rise strobe"}, sck_rise_o, (t != tp && (t % 2) == 1) ? 1 : 0);
         chk({tag, " R3 fall strobe"}, sck_fall_o, (t != tp && (t % 2) == 0) ? 1 : 0);
         tp = t;
      end
   endtask

   task automatic stop_run();
      en_i = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      int seed_v;
      seed_v = $urandom(32'h5EED_2510);
      do_reset();
      chk("R1 sck reset", sck_o, 0);
      chk("R1 rise reset", sck_rise_o, 0);
      chk("R1 fall reset", sck_fall_o, 0);
      chk("R1 err reset", ratio_err_o, 0);

      // R9 exact 7.8125 ratio
      run_check(125, 16, 250, 1'b0, "R9");
      stop_run();

      // random legal ratios with scrambled inputs while running (R6)
      for (int tr = 0; tr < 10; tr++) begin
         int den, num, lo;
         den = 1 + int'($urandom % 511);
         lo  = (den * 67 + 19) / 20;
         num = lo + int'($urandom % (32768 - lo));
         if (tr < 4) num = lo + int'($urandom % 40);
         run_check(num, den, 300, 1'b1, "RND");
         stop_run();
      end

      // R5 drop enable while sck high
      run_check(125, 16, 10, 1'b0, "R5pre");
      chk("R5 sck high before drop", sck_o, 1);
      en_i = 1'b0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk("R5 sck low when disabled", sck_o, 0);
         chk("R5 no strobe when disabled", sck_rise_o | sck_fall_o, 0);
      end
      chk("R7 no error on valid runs", ratio_err_o, 0);

      // R7 zero denominator
      num_i = 15'd100; den_i = 9'd0; en_i = 1'b1;
      @(negedge clk);
      chk("R7 err on zero den", ratio_err_o, 1);
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         chk("R7 idle sck", sck_o, 0);
         chk("R7 idle strobes", sck_rise_o | sck_fall_o, 0);
      end
      en_i = 1'b0;
      do_reset();
      chk("R8 err cleared by reset", ratio_err_o, 0);

      // R10 just below the limit is refused
      chk("R10 model below", ratio_ok(66, 20), 0);
      num_i = 15'd66; den_i = 9'd20; en_i = 1'b1;
      @(negedge clk);
      chk("R10 err at 66/20", ratio_err_o, 1);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk("R10 idle at 66/20", sck_o | sck_rise_o | sck_fall_o, 0);
      end
      stop_run();

      // R10 boundary accepted; R8 flag stays set
      chk("R10 model boundary", ratio_ok(67, 20), 1);
      run_check(67, 20, 200, 1'b0, "R10");
      chk("R8 err still set", ratio_err_o, 1);
      stop_run();
      chk("R8 err still set after stop", ratio_err_o, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule